// File: doc/BRIEF.md
# Dual Reloading Timer with Interrupts

Two independent down-counting timers sit behind a simple 32-bit register port that reads and writes in a single cycle. Each timer has a reload value, a readable current count and a control word. The control word carries a command and a tick-source select. A "load" command copies the reload value into the counter. "Hold" freezes the counter. "Run" makes it count down once per tick of the chosen source. When it expires, it reloads and raises its interrupt status bit.

Both status bits meet in one interrupt unit. That unit holds the raw status, an enable mask and a write-one-to-clear acknowledge register. A single level interrupt line is driven from the masked status. A free-running time counter advances on its own tick enable and can be read. The rate generators themselves live outside the block. They arrive as single-cycle enable inputs.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, every count reads 0. The raw status, the mask and the time counter read 0, and `irqOut` is low. Neither timer advances until software issues a run command, whatever the tick inputs do.
- R2: The command field is control bits [1:0]: 0 = load, 1 = hold, 2 = run. A write with the load command makes the count equal the stored reload value from the next cycle on, and it takes priority over a tick in the same cycle.
- R3: Writing a reload register only stores the value, and the value reads back. The current count is not changed until the next load or expiry.
- R4: While a timer is in hold, or has no active tick, its count stays unchanged.
- R5: The tick source is control bits [4:2], and control bits above 4 are ignored. Codes 4, 5, 6 and 7 select `tickSrc[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 mean an external or disabled source, and the counter never advances.
- R6: In run, each selected tick decrements the count by one. A tick that finds the count at 1 or 0 reloads the count from the reload register and sets raw status bit 0 (timer0) or bit 1 (timer1). The period is therefore the reload value in ticks, and every tick when the reload value is 0.
- R7: Writing the acknowledge register clears each raw status bit that is written as one and leaves the others alone. The written value is not stored, and the acknowledge offset reads 0.
- R8: The masked status reads as raw AND mask, using mask bits [1:0]. `irqOut` is high exactly when any masked bit is set, from the cycle after the write or expiry that changed it.
- R9: An expiry and an acknowledge of the same bit in the same cycle leave the bit set.
- R10: A control write with command 3 is ignored completely. The control value, the count and the source select all stay as they were.
- R11: The time counter advances by one on each cycle with `timeTick` high and wraps modulo 2^TIME_W. Writes to its offset have no effect.
- R12: Register byte offsets are as follows. Time 0x38, mask 0x48, acknowledge 0x4C, raw status 0x50, masked status 0x54. For timer0, reload 0x00, count 0x04, control 0x08. Timer1 uses the same three plus 0x10. Narrow values are zero-extended. Any other offset, including unaligned ones, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSrc | input | 4 | Four rate enables, selected per timer by source codes 4 to 7 |
| timeTick | input | 1 | Advance enable for the time counter |
| busAddr | input | 7 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Level interrupt, OR of the masked status |

## Verification
The bench builds the block with a 16-bit counter width and an 8-bit time counter. The narrow time counter brings the wrap of the free-running counter into reach in 256 ticks. The 16-bit counters show that reload values are truncated and zero-extended on readback. Small reload values, down to zero, make expiry, reload and the same-cycle collision between expiry and acknowledge happen within a handful of ticks.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int NUM_TMR = 2;
  localparam int ADDR_W  = 7;
  localparam int BUS_W   = 32;
  localparam int CTRL_W  = 5;

  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0,
    CMD_HOLD = 2'd1,
    CMD_RUN  = 2'd2,
    CMD_BAD  = 2'd3
  } cmd_e;

  // offsets within one timer's window
  localparam logic [ADDR_W-1:0] OFF_DIV    = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT    = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 7'h08;
  localparam int                TMR_STRIDE = 16;
  // shared registers
  localparam logic [ADDR_W-1:0] OFF_TIME   = 7'h38;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 7'h48;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 7'h4C;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 7'h50;
  localparam logic [ADDR_W-1:0] OFF_MSKD   = 7'h54;

  typedef struct packed {
    logic [NUM_TMR-1:0] load;
    logic [NUM_TMR-1:0] step;
  } tmr_strobe_t;
endpackage

// File: rtl/dtt_datapath.sv
module dtt_datapath
  import dtt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  tmr_strobe_t                     strobe,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   divVal,
  input  logic                            timeTick,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   cntVal,
  output logic [NUM_TMR-1:0]              expiry,
  output logic [TIME_W-1:0]               timeVal
);

  for (genvar i = 0; i < NUM_TMR; i++) begin : gTmr
    logic lastTick;
    assign lastTick  = cntVal[i] <= CNT_W'(1);
    assign expiry[i] = strobe.step[i] && !strobe.load[i] && lastTick;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntVal[i] <= '0;
      end else if (strobe.load[i]) begin
        cntVal[i] <= divVal[i];
      end else if (strobe.step[i]) begin
        cntVal[i] <= lastTick ? divVal[i] : cntVal[i] - CNT_W'(1);
      end
    end

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.load[i] && !strobe.step[i]) |=> cntVal[i] == $past(cntVal[i]));

    // R6
    reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      expiry[i] |=> cntVal[i] == $past(divVal[i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) timeVal <= '0;
    else if (timeTick) timeVal <= timeVal + TIME_W'(1);
  end

  // R11
  time_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeTick |=> timeVal == $past(timeVal) + TIME_W'(1));

endmodule

// File: rtl/dtt_ctrl.sv
module dtt_ctrl
  import dtt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWrEn,
  input  logic [BUS_W-1:0]                busWrData,
  input  logic [3:0]                      tickSrc,
  input  logic [NUM_TMR-1:0]              expiry,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   cntVal,
  input  logic [TIME_W-1:0]               timeVal,
  output tmr_strobe_t                     strobe,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   divVal,
  output logic [BUS_W-1:0]                busRdData,
  output logic                            irqOut
);

  logic [NUM_TMR-1:0][CTRL_W-1:0] ctrlReg;
  logic [NUM_TMR-1:0]             rawIrq;
  logic [NUM_TMR-1:0]             maskReg;
  logic [NUM_TMR-1:0]             loadVec;
  logic [NUM_TMR-1:0]             stepVec;
  logic                           wrAck;
  logic                           wrMask;
  logic                           cmdOk;

  assign wrAck  = busWrEn && (busAddr == OFF_ACK);
  assign wrMask = busWrEn && (busAddr == OFF_MASK);
  assign cmdOk  = busWrData[1:0] != CMD_BAD;

  for (genvar i = 0; i < NUM_TMR; i++) begin : gTmr
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * TMR_STRIDE);
    logic       wrDiv;
    logic       wrCtl;
    logic [2:0] srcSel;
    logic       tickHit;

    assign wrDiv   = busWrEn && (busAddr == BASE + OFF_DIV);
    assign wrCtl   = busWrEn && (busAddr == BASE + OFF_CTL);
    assign srcSel  = ctrlReg[i][4:2];
    assign tickHit = srcSel[2] && tickSrc[srcSel[1:0]];

    assign loadVec[i] = wrCtl && cmdOk && (busWrData[1:0] == CMD_LOAD);
    assign stepVec[i] = (ctrlReg[i][1:0] == CMD_RUN) && tickHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        divVal[i]  <= '0;
        ctrlReg[i] <= '0;
        rawIrq[i]  <= 1'b0;
      end else begin
        if (wrDiv) divVal[i] <= busWrData[CNT_W-1:0];
        if (wrCtl && cmdOk) ctrlReg[i] <= busWrData[CTRL_W-1:0];
        rawIrq[i] <= expiry[i] || (rawIrq[i] && !(wrAck && busWrData[i]));
      end
    end

    // R9
    expiry_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      expiry[i] |=> rawIrq[i]);

    // R10
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrCtl && busWrData[1:0] == CMD_BAD) |=> ctrlReg[i] == $past(ctrlReg[i]));
  end

  assign strobe = '{load: loadVec, step: stepVec};

  always_ff @(posedge clk) begin
    if (!rstN) maskReg <= '0;
    else if (wrMask) maskReg <= busWrData[NUM_TMR-1:0];
  end

  assign irqOut = |(rawIrq & maskReg);

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (busAddr == ADDR_W'(i * TMR_STRIDE) + OFF_DIV) busRdData = BUS_W'(divVal[i]);
      if (busAddr == ADDR_W'(i * TMR_STRIDE) + OFF_CNT) busRdData = BUS_W'(cntVal[i]);
      if (busAddr == ADDR_W'(i * TMR_STRIDE) + OFF_CTL) busRdData = BUS_W'(ctrlReg[i]);
    end
    case (busAddr)
      OFF_TIME: busRdData = BUS_W'(timeVal);
      OFF_MASK: busRdData = BUS_W'(maskReg);
      OFF_RAW:  busRdData = BUS_W'(rawIrq);
      OFF_MSKD: busRdData = BUS_W'(rawIrq & maskReg);
      default:  ;
    endcase
  end

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && (&busWrData[NUM_TMR-1:0]) && expiry == '0) |=> rawIrq == '0);

  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrMask && busWrData[NUM_TMR-1:0] == '0) |=> !irqOut);

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        tickSrc,
  input  logic              timeTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic              irqOut
);

  tmr_strobe_t                     strobe;
  logic [NUM_TMR-1:0][CNT_W-1:0]   divVal;
  logic [NUM_TMR-1:0][CNT_W-1:0]   cntVal;
  logic [NUM_TMR-1:0]              expiry;
  logic [TIME_W-1:0]               timeVal;

  dtt_ctrl #(.CNT_W(CNT_W), .TIME_W(TIME_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .tickSrc   (tickSrc),
    .expiry    (expiry),
    .cntVal    (cntVal),
    .timeVal   (timeVal),
    .strobe    (strobe),
    .divVal    (divVal),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

  dtt_datapath #(.CNT_W(CNT_W), .TIME_W(TIME_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .divVal   (divVal),
    .timeTick (timeTick),
    .cntVal   (cntVal),
    .expiry   (expiry),
    .timeVal  (timeVal)
  );

endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int TIME_W     = 8;

  localparam logic [6:0] A_DIV0 = 7'h00, A_CNT0 = 7'h04, A_CTL0 = 7'h08;
  localparam logic [6:0] A_DIV1 = 7'h10, A_CNT1 = 7'h14, A_CTL1 = 7'h18;
  localparam logic [6:0] A_TIME = 7'h38, A_MASK = 7'h48, A_ACK = 7'h4C;
  localparam logic [6:0] A_RAW  = 7'h50, A_MSKD = 7'h54;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  tickSrc = 4'h0;
  logic        timeTick = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_tick_timer #(.CNT_W(CNT_W), .TIME_W(TIME_W)) uut (
    .clk(clk), .rstN(rstN), .tickSrc(tickSrc), .timeTick(timeTick),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ctlWord(int src, int cmd);
    return 32'((src << 2) | cmd);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [6:0] addr, logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(string req, logic [6:0] addr, logic [31:0] exp);
    busAddr = addr;
    #1;
    check(req, busRdData, exp);
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    readCheck("R1 count0", A_CNT0, 0);
    readCheck("R1 count1", A_CNT1, 0);
    readCheck("R1 raw", A_RAW, 0);
    readCheck("R1 mask", A_MASK, 0);
    readCheck("R1 time", A_TIME, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
    tickSrc = 4'hF;
    edges(4);
    readCheck("R1 no advance", A_CNT0, 0);
    tickSrc = 4'h0;
  endtask

  task automatic testLoadHoldSource();
    busWrite(A_DIV0, 32'h0001_0005);       // upper bits truncated at CNT_W=16
    readCheck("R3 div readback", A_DIV0, 5);
    readCheck("R3 count untouched", A_CNT0, 0);
    busWrite(A_CTL0, ctlWord(0, 0));
    readCheck("R2 load", A_CNT0, 5);
    busWrite(A_DIV0, 9);
    readCheck("R3 divisor only stored", A_CNT0, 5);
    busWrite(A_DIV0, 5);
    tickSrc = 4'b0001;
    busWrite(A_CTL0, ctlWord(4, 2));
    edges(3);
    readCheck("R6 decrement", A_CNT0, 2);
    tickSrc = 4'b0000;
    busWrite(A_CTL0, ctlWord(4, 1));
    tickSrc = 4'b0001;
    edges(4);
    readCheck("R4 hold", A_CNT0, 2);
    busWrite(A_CTL0, ctlWord(5, 2));
    edges(3);
    readCheck("R5 other source idle", A_CNT0, 2);
    busWrite(A_CTL0, ctlWord(1, 2) | 32'h100);   // bit 8 ignored
    edges(3);
    readCheck("R5 disabled source", A_CNT0, 2);
    readCheck("R5 upper ctl bits dropped", A_CTL0, ctlWord(1, 2));
    busWrite(A_CTL0, ctlWord(4, 2));
    edges(1);
    readCheck("R6 count one", A_CNT0, 1);
    readCheck("R6 no expiry yet", A_RAW, 0);
    edges(1);
    tickSrc = 4'b0000;
    readCheck("R6 reload", A_CNT0, 5);
    readCheck("R6 raw bit0", A_RAW, 1);
    check("R8 masked off irq", {31'b0, irqOut}, 0);
  endtask

  task automatic testIrq();
    busWrite(A_MASK, 32'hFFFF_FFFD);       // only bit0 of [1:0] enabled
    readCheck("R8 mask", A_MASK, 1);
    readCheck("R8 masked", A_MSKD, 1);
    check("R8 irq high", {31'b0, irqOut}, 1);
    busWrite(A_ACK, 2);
    readCheck("R7 other bit kept", A_RAW, 1);
    busWrite(A_ACK, 1);
    readCheck("R7 cleared", A_RAW, 0);
    check("R7 irq low", {31'b0, irqOut}, 0);
    readCheck("R7 ack reads zero", A_ACK, 0);
  endtask

  task automatic testTimer1Collision();
    busWrite(A_DIV1, 0);
    busWrite(A_CTL1, ctlWord(0, 0));
    readCheck("R2 load zero", A_CNT1, 0);
    tickSrc = 4'b1000;
    busWrite(A_CTL1, ctlWord(7, 2));
    edges(1);
    readCheck("R6 timer1 bit1", A_RAW, 2);
    readCheck("R8 bit1 masked", A_MSKD, 0);
    check("R8 irq stays low", {31'b0, irqOut}, 0);
    busWrite(A_ACK, 2);
    readCheck("R9 expiry wins", A_RAW, 2);
    tickSrc = 4'b0000;
    busWrite(A_ACK, 2);
    readCheck("R7 bit1 cleared", A_RAW, 0);
  endtask

  task automatic testBadCmd();
    busWrite(A_DIV0, 7);
    busWrite(A_CTL0, ctlWord(5, 3));
    readCheck("R10 ctl kept", A_CTL0, ctlWord(4, 2));
    readCheck("R10 count kept", A_CNT0, 5);
    tickSrc = 4'b0010;
    edges(2);
    readCheck("R10 source kept", A_CNT0, 5);
    tickSrc = 4'b0000;
  endtask

  task automatic testTimeAndMap();
    timeTick = 1'b1;
    edges(10);
    timeTick = 1'b0;
    readCheck("R11 advance", A_TIME, 10);
    busWrite(A_TIME, 32'h55);
    readCheck("R11 write ignored", A_TIME, 10);
    timeTick = 1'b1;
    edges(256);
    timeTick = 1'b0;
    readCheck("R11 wrap", A_TIME, 10);
    readCheck("R12 unmapped 0x0C", 7'h0C, 0);
    readCheck("R12 unmapped 0x3C", 7'h3C, 0);
    readCheck("R12 unaligned", 7'h05, 0);
    busWrite(7'h09, ctlWord(0, 0));
    readCheck("R12 unaligned write ignored", A_CNT0, 5);
    readCheck("R12 timer1 ctl", A_CTL1, ctlWord(7, 2));
  endtask

  initial begin
    edges(3);
    rstN = 1'b1;
    testReset();
    testLoadHoldSource();
    testIrq();
    testTimer1Collision();
    testBadCmd();
    testTimeAndMap();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule